// File: doc/BRIEF.md
# Lockable Comma Word Aligner

This block sits after a deserializer that delivers 20 raw line bits per recovered word clock with no knowledge of where 10-bit characters begin. It keeps the previously accepted word and joins it with the incoming one into a 40-bit window. It searches that window for the 7-bit 8b/10b comma in either polarity. It then emits 20-bit words shifted so that bits [9:0] and [19:10] each hold one whole character, ready for two parallel character decoders.

Realignment can be frozen. While the link-up input is high, the first accepted word that carries a comma on its character boundary locks the current offset, and later comma-like patterns at other offsets are ignored. A bit error therefore cannot drag the alignment to a false boundary. A pulse on the sync-lost input releases the lock and restarts the search. Data enters and leaves through valid/ready streams. The output stage is a single register. A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled output word stays unchanged until it is taken. The control inputs `link_up` and `sync_lost` and the `offset` output are plain levels.

Top module: `comma_word_aligner`

## Requirements
- R1: The comma is the 7-bit run 0,0,1,1,1,1,1 or its complement 1,1,0,0,0,0,0, in arrival order. The window is {in_word, previous accepted word}, and window bit 0 (bit 0 of the previous word) is the earliest bit to arrive. A comma at window position p occupies window bits p..p+6, and the earliest bit is at p.
- R2: While search is enabled, if commas are found at several positions in 0..19 of one window, the lowest position becomes the offset.
- R3: For an accepted word with effective offset o, out_word[i] = window[o+i] for i in 0..19. out_word[9:0] is the first character and out_word[19:10] the second.
- R4: The offset and the output register change only on an accepted word. out_word, out_comma and out_valid appear on the clock edge that accepts the word, and the new offset takes effect at that same edge.
- R5: If link_up is high when a word is accepted whose aligned output holds a comma at bit 0 or bit 10, the aligner locks. While it is locked and sync_lost is low, the offset does not change, whatever commas arrive.
- R6: sync_lost high in any cycle clears the lock at the next edge. In the cycle sync_lost is high, search is enabled, so a comma accepted in that cycle or later sets a new offset.
- R7: While unlocked, every accepted word that contains a comma at positions 0..19 moves the offset to that comma's position.
- R8: out_comma is high with an output word exactly when that word has a comma (in the sense of R1) starting at bit 0 or at bit 10.
- R9: in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, out_word and out_comma hold and out_valid stays high.
- R10: After reset, out_valid is 0, the offset is 0, the aligner is unlocked and the stored previous word is all zeros.
- R11: While unlocked, an accepted word whose window has no comma at positions 0..19 keeps the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw word present |
| in_ready | output | 1 | Aligner can take a raw word |
| in_word | input | 20 | Raw deserialized bits, bit 0 earliest |
| link_up | input | 1 | Link is established; allows locking |
| sync_lost | input | 1 | Loss of synchronization; releases lock |
| out_valid | output | 1 | Aligned word present |
| out_ready | input | 1 | Downstream takes the aligned word |
| out_word | output | 20 | Aligned word, two 10-bit characters |
| out_comma | output | 1 | Aligned word holds a boundary comma |
| offset | output | 5 | Current alignment offset, 0..19 |

## Verification
The embedded properties check on every cycle that a locked offset stays frozen, that sync_lost always clears the lock, that the offset moves only on an accepted word and stays below 20, that the lowest matching position is chosen, and that a stalled output holds still. Which offset a given bit phase produces, both comma polarities, the content of each aligned word and its comma flag can only be shown by the bench's scenarios. The bench drives a continuous bit stream with commas at chosen phases and checks the results against a reference model and against fixed expected offsets. Random stalls, random link and loss-of-sync activity, and random data that can contain spurious commas exercise the lock behaviour.

// File: rtl/caw_pkg.sv
package caw_pkg;
  localparam int COMMA_LEN = 7;
  // earliest bit at index 0: arrival 0,0,1,1,1,1,1
  localparam logic [COMMA_LEN-1:0] COMMA_CODE = 7'b1111100;

  function automatic logic is_comma7(input logic [COMMA_LEN-1:0] s);
    return (s == COMMA_CODE) || (s == ~COMMA_CODE);
  endfunction
endpackage

// File: rtl/caw_comma_scan.sv
module caw_comma_scan
  import caw_pkg::*;
#(
  parameter int W  = 20,
  parameter int C  = 10,
  localparam int NPOS = W + C,
  localparam int OW   = $clog2(W)
) (
  input  logic [2*W-1:0]  win_i,
  output logic [NPOS-1:0] match_o,
  output logic            hit_o,
  output logic [OW-1:0]   pos_o
);
  genvar p;
  generate
    for (p = 0; p < NPOS; p++) begin : g_pos
      assign match_o[p] = is_comma7(win_i[p +: COMMA_LEN]);
    end
  endgenerate

  // lowest position among the W candidate offsets
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int q = W - 1; q >= 0; q--) begin
      if (match_o[q]) begin
        hit_o = 1'b1;
        pos_o = OW'(q);
      end
    end
  end
endmodule

// File: rtl/caw_word_shift.sv
module caw_word_shift #(
  parameter int W = 20,
  localparam int OW = $clog2(W)
) (
  input  logic [2*W-1:0] win_i,
  input  logic [OW-1:0]  sel_i,
  output logic [W-1:0]   word_o
);
  logic [2*W-1:0] shifted;
  always_comb begin
    shifted = win_i >> sel_i;
    word_o  = shifted[W-1:0];
  end
endmodule

// File: rtl/caw_lock_ctl.sv
module caw_lock_ctl #(
  parameter int W = 20,
  localparam int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          link_up_i,
  input  logic          sync_lost_i,
  input  logic          hit_i,
  input  logic [OW-1:0] pos_i,
  input  logic          aligned_i,
  output logic [OW-1:0] sel_o,
  output logic [OW-1:0] offset_o
);
  logic          lock_q;
  logic [OW-1:0] off_q;
  logic          search;

  assign search   = !lock_q || sync_lost_i;
  assign sel_o    = (search && hit_i) ? pos_i : off_q;
  assign offset_o = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (accept_i) off_q <= sel_o;
      if (sync_lost_i)
        lock_q <= 1'b0;
      else if (accept_i && link_up_i && aligned_i)
        lock_q <= 1'b1;
    end
  end

  p_locked_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !sync_lost_i) |=> $stable(off_q));

  p_loss_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost_i |=> !lock_q);
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int WORD_W = 20,
  parameter int CHAR_W = 10,
  localparam int OW   = $clog2(WORD_W),
  localparam int NPOS = WORD_W + CHAR_W,
  localparam int PW   = $clog2(NPOS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              link_up,
  input  logic              sync_lost,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_comma,
  output logic [OW-1:0]     offset
);
  logic [WORD_W-1:0]   prev_q;
  logic [2*WORD_W-1:0] win;
  logic [NPOS-1:0]     match;
  logic                hit;
  logic [OW-1:0]       pos;
  logic [OW-1:0]       sel;
  logic [WORD_W-1:0]   shifted;
  logic                aligned;
  logic                accept;
  logic [PW-1:0]       idx_lo, idx_hi;

  assign win      = {in_word, prev_q};
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  caw_comma_scan #(.W(WORD_W), .C(CHAR_W)) u_scan (
    .win_i(win), .match_o(match), .hit_o(hit), .pos_o(pos)
  );

  caw_lock_ctl #(.W(WORD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .link_up_i(link_up),
    .sync_lost_i(sync_lost), .hit_i(hit), .pos_i(pos), .aligned_i(aligned),
    .sel_o(sel), .offset_o(offset)
  );

  caw_word_shift #(.W(WORD_W)) u_shift (
    .win_i(win), .sel_i(sel), .word_o(shifted)
  );

  // comma on either character boundary of the selected alignment
  assign idx_lo  = PW'(sel);
  assign idx_hi  = PW'(sel) + PW'(CHAR_W);
  assign aligned = match[idx_lo] || match[idx_hi];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_comma <= 1'b0;
    end else if (accept) begin
      prev_q    <= in_word;
      out_word  <= shifted;
      out_comma <= aligned;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_comma)));

  p_offset_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(offset));

  p_offset_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    offset < OW'(WORD_W));

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[pos] && ((match[WORD_W-1:0] & ((WORD_W'(1) << pos) - WORD_W'(1))) == '0)));
endmodule

// File: tb/tb_comma_word_aligner.sv
module tb_comma_word_aligner;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [19:0] in_word = '0;
  logic        link_up = 0, sync_lost = 0;
  logic        out_valid, out_ready = 0, out_comma;
  logic [19:0] out_word;
  logic [4:0]  offset;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  comma_word_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .link_up(link_up), .sync_lost(sync_lost),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_comma(out_comma), .offset(offset)
  );

  // reference model state
  logic [19:0] m_prev = '0, m_data = '0;
  logic [4:0]  m_off = '0;
  bit          m_valid = 0, m_comma = 0, m_lock = 0;

  // bit stream builder
  logic [19:0] bacc = '0;
  int          bn = 0, tot = 0;
  logic [19:0] wq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic bit is_comma(input logic [39:0] w, input int p);
    logic [6:0] s;
    s = w[p +: 7];
    return (s == 7'b1111100) || (s == 7'b0000011);
  endfunction

  function automatic int first_comma(input logic [39:0] w);
    for (int p = 0; p < 20; p++) if (is_comma(w, p)) return p;
    return -1;
  endfunction

  task automatic tick(input bit iv, input logic [19:0] id, input bit ordy,
                      input bit lk, input bit ls, output bit acc);
    logic [39:0] win;
    int p, sel;
    bit al;
    in_valid = iv; in_word = id; out_ready = ordy; link_up = lk; sync_lost = ls;
    #1;
    chk(in_ready == (!m_valid || ordy), "R9 in_ready", 32'(in_ready), 32'(!m_valid || ordy));
    acc = iv && (!m_valid || ordy);
    win = {id, m_prev};
    p = first_comma(win);
    sel = ((!m_lock || ls) && p >= 0) ? p : int'(m_off);
    al = 0;
    if (acc) begin
      m_data  = win[sel +: 20];
      al      = is_comma(win, sel) || is_comma(win, sel + 10);
      m_comma = al;
      m_valid = 1;
      m_prev  = id;
      m_off   = 5'(sel);
    end else if (ordy) m_valid = 0;
    if (ls) m_lock = 0;
    else if (acc && lk && al) m_lock = 1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == m_valid, "R4 out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      chk(out_word == m_data, "R3 out_word", 32'(out_word), 32'(m_data));
      chk(out_comma == m_comma, "R8 out_comma", 32'(out_comma), 32'(m_comma));
    end
    chk(offset == m_off, "R7 offset model", 32'(offset), 32'(m_off));
  endtask

  task automatic push_bit(input logic b);
    bacc[bn] = b;
    bn++; tot++;
    if (bn == 20) begin wq.push_back(bacc); bn = 0; end
  endtask

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) push_bit(1'(tot % 2));
  endtask

  task automatic push_code(input logic [9:0] c);
    for (int i = 0; i < 10; i++) push_bit(c[i]);
  endtask

  // K28.5 comma character, earliest bit at index 0
  task automatic comma_train(input int ph, input int n, input bit rdp);
    for (int k = 0; k < n; k++) begin
      push_fill((ph - (tot % 20) + 20) % 20);
      push_code(rdp ? 10'h283 : 10'h17C);
    end
    push_fill(40);
  endtask

  task automatic feed(input bit lk, input bit rnd);
    bit acc;
    while (wq.size() > 0) begin
      if (rnd) tick(($urandom % 5) != 0, wq[0], ($urandom % 5) != 0,
                    ($urandom % 3) != 0, ($urandom % 12) == 0, acc);
      else tick(($urandom % 5) != 0, wq[0], ($urandom % 5) != 0, lk, 0, acc);
      if (acc) void'(wq.pop_front());
    end
    tick(0, '0, 1, lk, 0, acc);
  endtask

  task automatic lose_sync();
    bit acc;
    tick(0, '0, 1, 0, 1, acc);
  endtask

  initial begin
    bit acc;
    logic [19:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R10 out_valid after reset", 32'(out_valid), 0);
    chk(offset == 0, "R10 offset after reset", 32'(offset), 0);
    chk(in_ready == 1, "R10 in_ready after reset", 32'(in_ready), 1);
    @(negedge clk);

    // R1: negative-disparity comma at phase 7, link down
    comma_train(7, 3, 0); feed(0, 0);
    chk(offset == 7, "R1 offset phase 7", 32'(offset), 7);
    // R1: complement polarity at phase 13
    comma_train(13, 3, 1); feed(0, 0);
    chk(offset == 13, "R1 offset phase 13 complement", 32'(offset), 13);
    // R7: unlocked follows new phases
    comma_train(3, 2, 0); feed(0, 0);
    chk(offset == 3, "R7 offset phase 3", 32'(offset), 3);
    comma_train(16, 2, 1); feed(0, 0);
    chk(offset == 16, "R7 offset phase 16", 32'(offset), 16);
    // R11: no commas, offset held
    push_fill(200); feed(0, 0);
    chk(offset == 16, "R11 offset held without comma", 32'(offset), 16);
    // R2: two commas in one window, lowest (4) wins over 14
    push_fill((4 - (tot % 20) + 20) % 20);
    push_code(10'h17C); push_code(10'h283); push_fill(40); feed(0, 0);
    chk(offset == 4, "R2 lowest offset wins", 32'(offset), 4);
    // R5: lock at phase 5 with link up, then ignore phase 11
    lose_sync();
    comma_train(5, 3, 0); feed(1, 0);
    chk(offset == 5, "R5 locked offset", 32'(offset), 5);
    comma_train(11, 4, 1); feed(1, 0);
    chk(offset == 5, "R5 offset frozen against other phase", 32'(offset), 5);
    // R6: loss of sync releases, new phase taken
    lose_sync();
    comma_train(11, 3, 0); feed(1, 0);
    chk(offset == 11, "R6 realign after sync lost", 32'(offset), 11);
    // R9: stall holds data
    tick(1, 20'h5A5A5, 1, 1, 0, acc);
    held = out_word;
    tick(1, 20'h0F0F0, 0, 1, 0, acc);
    chk(acc == 0, "R9 no accept while stalled", 32'(acc), 0);
    #1;
    chk(in_ready == 0, "R9 in_ready low while stalled", 32'(in_ready), 0);
    chk(out_word == held, "R9 word held during stall", 32'(out_word), 32'(held));
    tick(0, '0, 1, 1, 0, acc);
    // random stream with occasional commas and random control
    lose_sync();
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) comma_train($urandom % 20, 1, ($urandom % 2) == 1);
      else push_bit(1'($urandom % 2));
      if (($urandom % 3) == 0) for (int j = 0; j < 20; j++) push_bit(1'($urandom % 2));
    end
    feed(0, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule